// File: doc/BRIEF.md
# DMA Completion Action Unit

This block runs once per finished DMA instruction. The engine hands it the decoded header fields of that instruction (transfer direction, counter select, counter-add flag, forced-interrupt flag, work-queue flag and the completion pointer) together with the total number of bytes moved. From these it decides which side effects happen. It can bump one of two completion counters, set one of two sticky interrupt flags, and raise exactly one pointer request. That request is either a work-queue-entry submit or a single-byte zero write to local memory.

The host reads both counters and both interrupt flags, and clears the flags by writing ones. Three global control bits shape the work. The first makes the counters count instructions instead of bytes. The second picks the byte-lane ordering of the zero write. The third turns on a per-core mode, in which a small nonzero pointer names a core whose event counter is incremented in place of a memory write. The unit accepts one instruction at a time and stays busy until its pointer request has been taken.

Top module: `dma_done_actions`

## Requirements
- R1: For a direction code of 0 (read local, write remote) or 3 (remote to remote) with the counter-add flag set, the counter chosen by the select bit (0 picks `cnt0_o`, 1 picks `cnt1_o`) grows by 1 when `cfg_add_one` is high, and by `done_bytes` otherwise.
- R2: For direction codes 1 (remote to local) and 2 (local to local), neither counter nor either interrupt flag changes, whatever the counter-add and interrupt flags say.
- R3: For direction codes 0 or 3 with the interrupt flag set, `fint_o[select]` becomes 1. It stays 1 until a host clear with the matching bit of `host_clr_mask` set. A set in the same cycle as a clear wins.
- R4: Counter and flag updates are visible in the cycle after the instruction is accepted. Any pointer request is raised one cycle later.
- R5: When the work-queue flag is 1 and the pointer is nonzero, `wq_valid` rises with `wq_ptr` equal to the pointer. Both are held until `wq_ready` is seen. Such a pointer has bits 2:0 at zero.
- R6: When the work-queue flag is 0, the pointer is nonzero and no per-core hit occurs, `zw_valid` rises. `zw_addr` is the pointer with bits 2:0 cleared. `zw_strb` is one-hot at bit k, where k = ptr[2:0] when `cfg_lane_le` is 1 and k = 7 - ptr[2:0] when it is 0. The request is held until `zw_ready` is seen.
- R7: A zero pointer raises no request, and the unit is ready again two cycles after acceptance.
- R8: With `cfg_core_mode` high, the work-queue flag 0 and 1 <= pointer <= 63, per-core counter number pointer-1 (read through `core_sel`/`core_cnt_o`) grows by one and no request is raised. A pointer of 64 or more in this mode gives a normal zero write.
- R9: `done_ready` is low from acceptance until the pointer request handshake completes. Only one request port is ever valid at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| done_valid | input | 1 | Finished instruction offered |
| done_ready | output | 1 | Unit idle, can accept |
| done_type | input | 2 | Direction code 0..3 |
| done_csel | input | 1 | Counter and flag select |
| done_cadd | input | 1 | Counter-add flag |
| done_fint | input | 1 | Forced-interrupt flag |
| done_wq | input | 1 | Pointer is a work-queue entry |
| done_ptr | input | PTR_W | Completion pointer |
| done_bytes | input | LEN_W | Bytes moved by the instruction |
| cfg_add_one | input | 1 | Count instructions instead of bytes |
| cfg_lane_le | input | 1 | Little-endian lane order for zero write |
| cfg_core_mode | input | 1 | Per-core counter mode |
| host_clr_valid | input | 1 | Host clear strobe |
| host_clr_mask | input | 2 | Write-one-to-clear mask for flags |
| cnt0_o | output | CNT_W | Completion counter 0 |
| cnt1_o | output | CNT_W | Completion counter 1 |
| fint_o | output | 2 | Forced-interrupt flags |
| core_sel | input | 6 | Per-core counter read index |
| core_cnt_o | output | CORE_W | Selected per-core counter |
| wq_valid | output | 1 | Work-queue submit request |
| wq_ready | input | 1 | Submit accepted |
| wq_ptr | output | PTR_W | Work-queue entry pointer |
| zw_valid | output | 1 | Zero-byte write request |
| zw_ready | input | 1 | Zero write accepted |
| zw_addr | output | PTR_W | Word-aligned write address |
| zw_strb | output | 8 | One-hot byte strobe |

## Verification
The hardest case to reach is the boundary between per-core mode and the ordinary zero write. Pointers 1 to 63 must touch only a core counter. Pointer 64 and pointer 0 must fall back to their own paths, and a work-queue flag must turn the core mode off. The stimulus walks every pointer from 1 to 63 with core mode on and reads each core counter back through the read port. It then sends 0, 64 and a work-queue instruction in the same mode. A separate sweep crosses all four directions with the select, add, interrupt and add-one bits, and a final case sets a flag while the host clears it in the same cycle.

// File: rtl/dma_done_actions.sv
module dma_done_actions #(
  parameter int PTR_W  = 40,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int CORES  = 63,
  parameter int CORE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_valid,
  output logic              done_ready,
  input  logic [1:0]        done_type,
  input  logic              done_csel,
  input  logic              done_cadd,
  input  logic              done_fint,
  input  logic              done_wq,
  input  logic [PTR_W-1:0]  done_ptr,
  input  logic [LEN_W-1:0]  done_bytes,
  input  logic              cfg_add_one,
  input  logic              cfg_lane_le,
  input  logic              cfg_core_mode,
  input  logic              host_clr_valid,
  input  logic [1:0]        host_clr_mask,
  output logic [CNT_W-1:0]  cnt0_o,
  output logic [CNT_W-1:0]  cnt1_o,
  output logic [1:0]        fint_o,
  input  logic [5:0]        core_sel,
  output logic [CORE_W-1:0] core_cnt_o,
  output logic              wq_valid,
  input  logic              wq_ready,
  output logic [PTR_W-1:0]  wq_ptr,
  output logic              zw_valid,
  input  logic              zw_ready,
  output logic [PTR_W-1:0]  zw_addr,
  output logic [7:0]        zw_strb
);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_WQ, S_ZW} state_t;

  state_t             state_q;
  state_t             kind_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               le_q;
  logic [CNT_W-1:0]   cnt_q [2];
  logic [1:0]         fint_q;
  logic [CORE_W-1:0]  core_q [CORES];

  wire take      = done_valid && done_ready;
  wire counts_ok = (done_type == 2'd0) || (done_type == 2'd3);
  wire ptr_nz    = |done_ptr;
  wire ptr_small = ptr_nz && (done_ptr[PTR_W-1:6] == '0);
  wire core_hit  = cfg_core_mode && !done_wq && ptr_small;
  wire [5:0] core_idx = done_ptr[5:0] - 6'd1;
  wire [CNT_W-1:0] add_val = cfg_add_one ? CNT_W'(1) : CNT_W'(done_bytes);

  assign done_ready = (state_q == S_IDLE);
  assign cnt0_o     = cnt_q[0];
  assign cnt1_o     = cnt_q[1];
  assign fint_o     = fint_q;
  assign core_cnt_o = (core_sel < 6'(CORES)) ? core_q[core_sel] : '0;
  assign wq_valid   = (state_q == S_WQ);
  assign wq_ptr     = ptr_q;
  assign zw_valid   = (state_q == S_ZW);
  assign zw_addr    = {ptr_q[PTR_W-1:3], 3'b000};
  assign zw_strb    = 8'b1 << (le_q ? ptr_q[2:0] : ~ptr_q[2:0]);

  generate
    for (genvar i = 0; i < 2; i++) begin : g_side
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[i]  <= '0;
          fint_q[i] <= 1'b0;
        end else begin
          if (take && counts_ok && done_cadd && (done_csel == 1'(i)))
            cnt_q[i] <= cnt_q[i] + add_val;
          fint_q[i] <= (fint_q[i] && !(host_clr_valid && host_clr_mask[i]))
                       || (take && counts_ok && done_fint && (done_csel == 1'(i)));
        end
      end
    end
    for (genvar j = 0; j < CORES; j++) begin : g_core
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          core_q[j] <= '0;
        else if (take && core_hit && (core_idx == 6'(j)))
          core_q[j] <= core_q[j] + CORE_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= S_IDLE;
      ptr_q   <= '0;
      le_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (take) begin
          state_q <= S_ARM;
          ptr_q   <= done_ptr;
          le_q    <= cfg_lane_le;
          if (ptr_nz && done_wq)        kind_q <= S_WQ;
          else if (ptr_nz && !core_hit) kind_q <= S_ZW;
          else                          kind_q <= S_IDLE;
        end
        S_ARM:   state_q <= kind_q;
        S_WQ:    if (wq_ready) state_q <= S_IDLE;
        default: if (zw_ready) state_q <= S_IDLE;
      endcase
    end
  end

  AST_NO_CNT_INBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    take && !counts_ok |=> $stable(cnt0_o) && $stable(cnt1_o)); // R2
  AST_FINT_SET0: assert property (@(posedge clk) disable iff (!rst_n)
    take && counts_ok && done_fint && !done_csel |=> fint_o[0]); // R3
  AST_WQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    take && done_wq && ptr_nz |-> done_ptr[2:0] == 3'b000); // R5
  AST_WQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wq_valid && !wq_ready |=> wq_valid && $stable(wq_ptr)); // R5
  AST_ZW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    zw_valid && !zw_ready |=> zw_valid && $stable(zw_addr) && $stable(zw_strb)); // R6
  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    zw_valid |-> $onehot(zw_strb)); // R6
  AST_NO_REQ_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !wq_valid && !zw_valid); // R4
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(wq_valid && zw_valid)); // R9
  AST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_valid || zw_valid) |-> !done_ready); // R9

endmodule

// File: tb/dma_done_actions_tb.sv
module dma_done_actions_tb;
  localparam int PTR_W = 40, CNT_W = 32, LEN_W = 16, CORES = 63, CORE_W = 16;

  logic clk = 0, rst_n = 0;
  logic done_valid = 0, done_ready;
  logic [1:0] done_type = 0;
  logic done_csel = 0, done_cadd = 0, done_fint = 0, done_wq = 0;
  logic [PTR_W-1:0] done_ptr = 0;
  logic [LEN_W-1:0] done_bytes = 0;
  logic cfg_add_one = 0, cfg_lane_le = 0, cfg_core_mode = 0;
  logic host_clr_valid = 0;
  logic [1:0] host_clr_mask = 0;
  logic [CNT_W-1:0] cnt0_o, cnt1_o;
  logic [1:0] fint_o;
  logic [5:0] core_sel = 0;
  logic [CORE_W-1:0] core_cnt_o;
  logic wq_valid, wq_ready = 0, zw_valid, zw_ready = 0;
  logic [PTR_W-1:0] wq_ptr, zw_addr;
  logic [7:0] zw_strb;

  int checks = 0, fails = 0;
  longint ecnt [2];
  bit efint [2];
  int ecore [CORES];

  always #10 clk = ~clk;

  dma_done_actions #(.PTR_W(PTR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .CORES(CORES), .CORE_W(CORE_W)) u_dut (
    .clk, .rst_n, .done_valid, .done_ready, .done_type, .done_csel, .done_cadd,
    .done_fint, .done_wq, .done_ptr, .done_bytes, .cfg_add_one, .cfg_lane_le,
    .cfg_core_mode, .host_clr_valid, .host_clr_mask, .cnt0_o, .cnt1_o, .fint_o,
    .core_sel, .core_cnt_o, .wq_valid, .wq_ready, .wq_ptr, .zw_valid, .zw_ready,
    .zw_addr, .zw_strb);

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_side(string req);
    chk(cnt0_o == CNT_W'(ecnt[0]), req, cnt0_o, ecnt[0]);
    chk(cnt1_o == CNT_W'(ecnt[1]), req, cnt1_o, ecnt[1]);
    chk(fint_o == {efint[1], efint[0]}, req, fint_o, {efint[1], efint[0]});
  endtask

  task automatic run(input logic [1:0] ty, input bit c, ca, fi, wq,
                     input logic [PTR_W-1:0] ptr, input logic [LEN_W-1:0] nb,
                     input int stall, input string req);
    int kind;
    bit hit;
    logic [7:0] es;
    @(negedge clk);
    while (!done_ready) @(negedge clk);
    done_type = ty; done_csel = c; done_cadd = ca; done_fint = fi;
    done_wq = wq; done_ptr = ptr; done_bytes = nb; done_valid = 1;
    @(negedge clk);
    done_valid = 0;
    if (ty == 0 || ty == 3) begin
      if (ca) ecnt[c] += cfg_add_one ? 1 : nb;
      if (fi) efint[c] = 1;
    end
    hit = cfg_core_mode && !wq && ptr != 0 && ptr < 64;
    if (hit) ecore[ptr - 1]++;
    kind = (ptr == 0) ? 0 : wq ? 1 : hit ? 0 : 2;
    check_side(req);
    chk(!done_ready && !wq_valid && !zw_valid, "R4", {done_ready, wq_valid, zw_valid}, 0);
    @(negedge clk);
    if (kind == 0) begin
      chk(done_ready && !wq_valid && !zw_valid, "R7", {done_ready, wq_valid, zw_valid}, 4);
    end else begin
      if (kind == 1) begin
        chk(wq_valid && !zw_valid, "R5", {wq_valid, zw_valid}, 2);
        chk(wq_ptr == ptr, "R5", wq_ptr, ptr);
      end else begin
        es = 8'b1 << (cfg_lane_le ? ptr % 8 : 7 - ptr % 8);
        chk(zw_valid && !wq_valid, "R6", {zw_valid, wq_valid}, 2);
        chk(zw_addr == (ptr / 8) * 8, "R6", zw_addr, (ptr / 8) * 8);
        chk(zw_strb == es, "R6", zw_strb, es);
      end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(!done_ready && (wq_valid || zw_valid), "R9", done_ready, 0);
      end
      wq_ready = 1; zw_ready = 1;
      @(negedge clk);
      wq_ready = 0; zw_ready = 0;
      chk(done_ready && !wq_valid && !zw_valid, "R9", {done_ready, wq_valid, zw_valid}, 4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ecnt[0] = 0; ecnt[1] = 0; efint[0] = 0; efint[1] = 0;
    for (int i = 0; i < CORES; i++) ecore[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_side("R1 reset");
    chk(done_ready && !wq_valid && !zw_valid, "R9 reset", done_ready, 1);

    // R1 R2 R3: sweep of direction, select, add, interrupt and count mode
    for (int a1 = 0; a1 < 2; a1++)
      for (int ty = 0; ty < 4; ty++)
        for (int c = 0; c < 2; c++)
          for (int ca = 0; ca < 2; ca++)
            for (int fi = 0; fi < 2; fi++) begin
              cfg_add_one = 1'(a1);
              run(2'(ty), 1'(c), 1'(ca), 1'(fi), 0, 0, 16'(37 * ty + 11 * c + 1000 * a1 + 5),
                  0, (ty == 1 || ty == 2) ? "R2" : "R1");
              host_clr_valid = 1; host_clr_mask = 2'b11;
              @(negedge clk);
              host_clr_valid = 0;
              efint[0] = 0; efint[1] = 0;
              chk(fint_o == 2'b00, "R3 clear", fint_o, 0);
            end
    cfg_add_one = 0;

    // R3: selective clear and set-wins
    run(0, 0, 0, 1, 0, 0, 1, 0, "R3");
    run(3, 1, 0, 1, 0, 0, 1, 0, "R3");
    host_clr_valid = 1; host_clr_mask = 2'b01;
    @(negedge clk);
    host_clr_valid = 0;
    efint[0] = 0;
    chk(fint_o == 2'b10, "R3 w1c", fint_o, 2);
    @(negedge clk);
    done_type = 0; done_csel = 1; done_fint = 1; done_cadd = 0; done_wq = 0; done_ptr = 0;
    done_valid = 1; host_clr_valid = 1; host_clr_mask = 2'b10;
    @(negedge clk);
    done_valid = 0; host_clr_valid = 0; done_fint = 0;
    chk(fint_o == 2'b10, "R3 set wins", fint_o, 2);
    repeat (2) @(negedge clk);

    // R5: work-queue submits with stalls
    run(1, 0, 0, 0, 1, 40'h12_3456_7808, 64, 0, "R5");
    run(0, 1, 1, 0, 1, 40'hFF_FFFF_FFF8, 9, 3, "R5");

    // R6: every byte offset in both lane orders
    for (int le = 0; le < 2; le++)
      for (int off = 0; off < 8; off++) begin
        cfg_lane_le = 1'(le);
        run(2, 0, 0, 0, 0, 40'hA0_0000_1000 + 40'(off), 8, off % 3, "R6");
      end

    // R8: per-core mode over every small pointer
    cfg_core_mode = 1;
    for (int p = 1; p < 64; p++) begin
      run(2'(p % 4), 0, 0, 0, 0, 40'(p), 4, 0, "R8");
      core_sel = 6'(p - 1);
      #1;
      chk(core_cnt_o == CORE_W'(ecore[p - 1]), "R8", core_cnt_o, ecore[p - 1]);
    end
    run(2, 0, 0, 0, 0, 40'd7, 4, 0, "R8");
    core_sel = 6;
    #1;
    chk(core_cnt_o == CORE_W'(ecore[6]), "R8 second hit", core_cnt_o, ecore[6]);
    run(2, 0, 0, 0, 0, 40'd64, 4, 1, "R8 boundary");
    run(2, 0, 0, 0, 1, 40'd16, 4, 0, "R8 wq");
    run(0, 0, 1, 0, 0, 40'd0, 4, 0, "R7");
    cfg_core_mode = 0;
    run(3, 1, 1, 1, 0, 40'd5, 300, 2, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule